// File: doc/BRIEF.md
# Interrupt Message Vector Store

This block is a memory-mapped register file. It holds a table of message-signalled interrupt vectors and a bit array of pending vectors for a parameterised number of vectors `NVEC`. Software reaches it through a 32-bit slave port that decodes the low 16 address bits. Each vector owns a 16-byte entry made of four words: a target address split into a low word and a high word, a payload word, and a control word whose bit 0 masks the vector.

A dispatcher on the side reads any entry combinationally by index, and sees the pending bits as a flat vector. It sets and clears pending bits through per-vector strobes. Software can read the pending bits but cannot write them. Each accepted write to an entry raises a one-cycle re-check request that carries that entry's index. The dispatcher uses it to decide whether a parked vector can now be sent.

Top module: `msix_vector_store`

## Requirements
- R1: The word at byte offset i*16 + k*4, for i < NVEC, is word k of entry i (0 address low, 1 address high, 2 payload, 3 control). A 4-byte access writes it or reads it back, and table storage starts at offset 0.
- R2: For an index below NVEC, the dispatcher outputs are combinational. `disp_addr` = {address high, address low with bits 1:0 forced to zero}, `disp_data` = payload, and `disp_masked` = control bit 0. An index of NVEC or above gives all zeros.
- R3: Pending bits read from offset NVEC*16. Vector i sits in byte i/8 at bit i mod 8, so the first word holds vectors 0..31 with vector 0 in bit 0. Words in the region past the last pending byte read zero.
- R4: The region spans (NVEC*16 + ceil(NVEC/8)) rounded up to a multiple of 4096 bytes. A read whose last byte lies past the region returns 0xFFFFFFFF with no error.
- R5: A request is rejected with `rsp_err`=1 and `rsp_rdata`=0 when `req_size` is not 2 (4 bytes; 0=1 byte, 1=2 bytes, 3=8 bytes) or when address bits 1:0 are not zero. A rejected write changes nothing and raises no re-check.
- R6: A write at offset NVEC*16 or above is dropped without error. It leaves the pending bits and the table unchanged and raises no re-check.
- R7: One cycle after an accepted table write, `recheck_valid` pulses for one cycle with `recheck_idx` = offset/16.
- R8: `pend_set` and `pend_clr` update `pend_vec` at the next clock edge. Set wins over clear for the same vector.
- R9: Reset clears all table words and pending bits, and drops `rsp_valid` and `recheck_valid`.
- R10: Every request gets exactly one response, with `rsp_valid` high in the cycle after it. `rsp_valid` is low in the cycle after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset in the region |
| req_size | input | 2 | log2 of access bytes; only 2 accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, cycle after request |
| rsp_err | output | 1 | Request rejected for size or alignment |
| rsp_rdata | output | 32 | Read data |
| disp_idx | input | IDX_W | Entry selected by dispatcher |
| disp_addr | output | 64 | Target address of selected entry |
| disp_data | output | 32 | Payload of selected entry |
| disp_masked | output | 1 | Mask bit of selected entry |
| pend_set | input | NVEC | Per-vector pending set strobes |
| pend_clr | input | NVEC | Per-vector pending clear strobes |
| pend_vec | output | NVEC | Pending bits |
| recheck_valid | output | 1 | Entry written, re-check pending state |
| recheck_idx | output | IDX_W | Index of written entry |

## Verification
Bus responses and re-check pulses are registered. They are due in the cycle after the request, so the bench drives a request on a falling edge and samples `rsp_*` and `recheck_*` on the next falling edge. Pending strobes act at the next rising edge, and `pend_vec` is checked one falling edge after they are driven. The dispatcher outputs are combinational, so they are sampled a short delay after `disp_idx` changes, with the clock quiet between edges.

// File: rtl/msix_vector_store.sv
module msix_vector_store #(
  parameter int unsigned NVEC  = 8,
  parameter int unsigned IDX_W = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [15:0]      req_addr,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata,
  input  logic [IDX_W-1:0] disp_idx,
  output logic [63:0]      disp_addr,
  output logic [31:0]      disp_data,
  output logic             disp_masked,
  input  logic [NVEC-1:0]  pend_set,
  input  logic [NVEC-1:0]  pend_clr,
  output logic [NVEC-1:0]  pend_vec,
  output logic             recheck_valid,
  output logic [IDX_W-1:0] recheck_idx
);
  localparam int unsigned TBL_WORDS = NVEC * 4;
  localparam int unsigned TBL_BYTES = NVEC * 16;
  localparam int unsigned PBA_BYTES = (NVEC + 7) / 8;
  localparam int unsigned REGION    = ((TBL_BYTES + PBA_BYTES + 4095) / 4096) * 4096;
  localparam int unsigned PBA_WORDS = (NVEC + 31) / 32;
  localparam int unsigned PBAW      = PBA_WORDS * 32;
  localparam int unsigned TW_W      = $clog2(TBL_WORDS);

  logic [31:0] mem [TBL_WORDS];
  logic [31:0] wi;
  logic        size_ok, wr_ok;
  logic [31:0] rd;
  logic [PBAW-1:0] pend_pad;

  assign wi       = {18'd0, req_addr[15:2]};
  assign size_ok  = (req_size == 2'd2) && (req_addr[1:0] == 2'b00);
  assign wr_ok    = req_valid && req_write && size_ok && (wi < TBL_WORDS);
  assign pend_pad = PBAW'(pend_vec);

  always_comb begin
    rd = '0;
    if ((wi << 2) + 32'd4 > REGION) rd = '1;
    else if (wi < TBL_WORDS) rd = mem[wi[TW_W-1:0]];
    else
      for (int unsigned k = 0; k < PBA_WORDS; k++)
        if (wi - TBL_WORDS == k) rd = pend_pad[k*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(TBL_WORDS); i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[wi[TW_W-1:0]] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_err       <= 1'b0;
      rsp_rdata     <= '0;
      recheck_valid <= 1'b0;
      recheck_idx   <= '0;
      pend_vec      <= '0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_err       <= req_valid && !size_ok;
      rsp_rdata     <= (req_valid && size_ok && !req_write) ? rd : 32'd0;
      recheck_valid <= wr_ok;
      if (wr_ok) recheck_idx <= IDX_W'(req_addr[15:4]);
      pend_vec      <= (pend_vec & ~pend_clr) | pend_set;
    end
  end

  logic        d_ok;
  logic [31:0] d_lo, d_hi, d_ctl;
  assign d_ok  = 32'(disp_idx) < NVEC;
  assign d_lo  = d_ok ? mem[TW_W'({disp_idx, 2'b00})] : 32'd0;
  assign d_hi  = d_ok ? mem[TW_W'({disp_idx, 2'b01})] : 32'd0;
  assign disp_data = d_ok ? mem[TW_W'({disp_idx, 2'b10})] : 32'd0;
  assign d_ctl = d_ok ? mem[TW_W'({disp_idx, 2'b11})] : 32'd0;
  assign disp_addr   = {d_hi, d_lo & 32'hFFFF_FFFC};
  assign disp_masked = d_ctl[0];

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'd2) |=> (rsp_err && rsp_rdata == 32'd0 && !recheck_valid));
  assert_pba_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && {16'd0, req_addr} >= TBL_BYTES) |=> !recheck_valid);
  assert_recheck_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    recheck_valid |-> ($past(req_valid && req_write) && recheck_idx == IDX_W'($past(req_addr[15:4]))));
  assert_outside_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'd2 && req_addr[1:0] == 2'b00 &&
     {16'd0, req_addr} + 32'd4 > REGION) |=> (rsp_rdata == 32'hFFFF_FFFF && !rsp_err));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_set) |=> ((pend_vec & $past(pend_set)) == $past(pend_set)));
endmodule

// File: tb/test_msix_vector_store.sv
module test_msix_vector_store;
  localparam int N = 12;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [1:0] req_size = 2;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [IW-1:0] disp_idx = 0;
  logic [63:0] disp_addr;
  logic [31:0] disp_data;
  logic disp_masked;
  logic [N-1:0] pend_set = 0, pend_clr = 0, pend_vec;
  logic recheck_valid;
  logic [IW-1:0] recheck_idx;

  int checks = 0, failures = 0;

  msix_vector_store #(.NVEC(N)) i_msix_vector_store (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .disp_idx(disp_idx), .disp_addr(disp_addr), .disp_data(disp_data),
    .disp_masked(disp_masked), .pend_set(pend_set), .pend_clr(pend_clr),
    .pend_vec(pend_vec), .recheck_valid(recheck_valid), .recheck_idx(recheck_idx));

  always #10 clk = ~clk;

  function automatic logic [31:0] pat(int w);
    return (32'h9E37_79B9 * 32'(w + 1)) ^ 32'(w >> 2);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [15:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic pend_drive(logic [N-1:0] s, logic [N-1:0] c);
    @(negedge clk);
    pend_set = s; pend_clr = c;
    @(negedge clk);
    pend_set = 0; pend_clr = 0;
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk("R9 rsp_valid", 64'(rsp_valid), 0);
    chk("R9 recheck", 64'(recheck_valid), 0);
    chk("R9 pend", 64'(pend_vec), 0);
    #1 chk("R9 disp_data", 64'(disp_data), 0);
    access(0, 16'd0, 2, 0);
    chk("R9 word0", 64'(rsp_rdata), 0);
    access(0, 16'd192, 2, 0);
    chk("R9 pba", 64'(rsp_rdata), 0);
    @(negedge clk);
    chk("R10 idle", 64'(rsp_valid), 0);

    // R1, R7 writes of every table word
    for (int w = 0; w < N * 4; w++) begin
      access(1, 16'(w * 4), 2, pat(w));
      chk("R10 wr rsp", 64'({rsp_valid, rsp_err}), 64'b10);
      chk("R7 recheck", 64'({recheck_valid, recheck_idx}), 64'({1'b1, 4'(w / 4)}));
    end
    @(negedge clk);
    chk("R7 pulse one cycle", 64'(recheck_valid), 0);
    for (int w = 0; w < N * 4; w++) begin
      access(0, 16'(w * 4), 2, 0);
      chk("R1 readback", 64'({rsp_err, rsp_rdata}), 64'({1'b0, pat(w)}));
    end

    // R2 dispatcher
    for (int i = 0; i < 16; i++) begin
      disp_idx = 4'(i);
      #1;
      if (i < N) begin
        chk("R2 addr", disp_addr, {pat(4*i+1), pat(4*i) & 32'hFFFF_FFFC});
        chk("R2 data", 64'(disp_data), 64'(pat(4*i+2)));
        chk("R2 mask", 64'(disp_masked), 64'(pat(4*i+3) & 1));
      end else begin
        chk("R2 out of range", {disp_addr[31:0], disp_data, 31'd0, disp_masked}, 0);
      end
    end

    // R3, R8 pending array
    for (int i = 0; i < N; i++) begin
      pend_drive(0, '1);
      pend_drive(N'(1) << i, 0);
      chk("R8 set", 64'(pend_vec), 64'(N'(1) << i));
      access(0, 16'd192, 2, 0);
      chk("R3 pba walk", 64'(rsp_rdata), 64'(32'd1 << i));
    end
    pend_drive(0, '1);
    pend_drive(12'hA5C, 0);
    access(0, 16'd192, 2, 0);
    chk("R3 pba pattern", 64'(rsp_rdata), 64'h0A5C);
    pend_drive(12'h00C, 12'h00F);
    chk("R8 set wins", 64'(pend_vec), 64'hA5C);
    pend_drive(0, 12'h00C);
    chk("R8 clear", 64'(pend_vec), 64'hA50);
    access(0, 16'd196, 2, 0);
    chk("R3 past pba zero", 64'(rsp_rdata), 0);

    // R4 region edge
    access(0, 16'd4092, 2, 0);
    chk("R4 last word", 64'({rsp_err, rsp_rdata}), 0);
    access(0, 16'd4096, 2, 0);
    chk("R4 outside", 64'({rsp_err, rsp_rdata}), 64'h0FFFF_FFFF);
    access(0, 16'hFFFC, 2, 0);
    chk("R4 top", 64'({rsp_err, rsp_rdata}), 64'h0FFFF_FFFF);

    // R5 rejected sizes and alignment
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      access(0, 16'd4, 2'(s), 0);
      chk("R5 read size", 64'({rsp_valid, rsp_err, rsp_rdata}), 64'({2'b11, 32'd0}));
      access(1, 16'd0, 2'(s), 32'hDEAD_BEEF);
      chk("R5 write no recheck", 64'({rsp_err, recheck_valid}), 64'b10);
    end
    access(1, 16'd2, 2, 32'hDEAD_BEEF);
    chk("R5 misaligned", 64'({rsp_err, recheck_valid}), 64'b10);
    access(0, 16'd0, 2, 0);
    chk("R5 word0 kept", 64'(rsp_rdata), 64'(pat(0)));

    // R6 writes into pba and beyond
    access(1, 16'd192, 2, 32'h0);
    chk("R6 no recheck", 64'({rsp_err, recheck_valid}), 0);
    access(0, 16'd192, 2, 0);
    chk("R6 pba kept", 64'(rsp_rdata), 64'hA50);
    chk("R6 pend kept", 64'(pend_vec), 64'hA50);
    access(1, 16'd4096, 2, 32'h1234);
    chk("R6 outside no recheck", 64'(recheck_valid), 0);
    access(0, 16'd188, 2, 0);
    chk("R6 table kept", 64'(rsp_rdata), 64'(pat(47)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule